// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block combines an up-counting timer, one compare register and a single waveform output pin. A control register holds two mode fields. The waveform mode selects how the counter runs: a free run that wraps at the all-ones value, clear-on-compare, or fast PWM with its top at either all-ones or the compare value. The output mode selects what the pin does on a compare match and, in fast PWM, what it does when the counter wraps back to zero.

The counter moves only on cycles where the clock-enable tick is high, so an outside prescaler sets the rate. Software writes the control and compare registers through a small write port. In fast PWM the compare value is double-buffered and reloads when the counter wraps. The output-enable flag tells the surrounding pad logic whether the unit owns the pin, based on the output mode and an external direction bit.

Top module: `cwu_top`

## Requirements
- R1: After reset the counter, the output register, both mode fields and the compare register are zero, and the output-enable flag is low.
- R2: Writes to address 0 load the waveform mode from data bits [2:0] and the output mode from bits [5:4]. Writes to address 1 load the compare value. Writes to any other address change nothing. Waveform codes: 000 free run, 010 clear-on-compare, 011 fast PWM with all-ones top, 111 fast PWM with compare top. Every other code behaves as 000.
- R3: The counter changes only on a tick. On a tick where it equals TOP it goes to zero, and otherwise it adds one. TOP is the compare value in codes 010 and 111 and all-ones in the others.
- R4: The output-enable flag is high only when the direction input is high and the output mode is nonzero. The one exception is fast PWM with output mode 01 and waveform bit 2 clear, where the flag stays low.
- R5: In the non-PWM codes, on a tick where the counter equals the compare value, output mode 01 toggles the output, 10 clears it and 11 sets it. The new level is visible after that clock edge.
- R6: In fast PWM with output mode 10, a tick at the compare value clears the output and a tick at TOP (the wrap to zero) sets it.
- R7: In fast PWM with output mode 11, a tick at the compare value sets the output and a tick at TOP clears it.
- R8: In fast PWM with output mode 01, the output toggles on a compare match when waveform bit 2 is set. When that bit is clear, the output register keeps its level.
- R9: In fast PWM with output mode 10 or 11, if the compare value equals TOP then the compare match has no effect and only the wrap action takes place.
- R10: In fast PWM a compare write goes to a buffer, and the active compare value takes the buffered value on the tick where the counter wraps. In the non-PWM codes a compare write takes effect on that clock edge.
- R11: While the output mode is 00 the output register keeps its level. When a nonzero mode is selected again, the waveform continues from that level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0 control, 1 compare) |
| wr_data | input | CNT_W | Register write data |
| tick_i | input | 1 | Counting enable for this cycle |
| pin_dir_i | input | 1 | Direction bit of the pin (1 = output) |
| count_o | output | CNT_W | Current counter value |
| wave_o | output | 1 | Output register level |
| wave_oe_o | output | 1 | High when the unit drives the pin |

## Verification
The assertions assume that a mode or compare write and a tick in the same cycle act on the mode that was in force before that edge. They also assume that the direction bit is a plain level with no timing of its own. The stimulus writes registers only on cycles with the tick low, so every mode change lands between two counting steps. It leaves a fast PWM setting only after a wrap has copied the compare buffer into the active value. Gaps in the tick stream and direction changes are applied while the counter is running, which exercises the hold and output-enable properties under real traffic.

// File: rtl/cwu_pkg.sv
package cwu_pkg;

   localparam int WM_W      = 3;
   localparam int OM_W      = 2;
   localparam int WM_LSB    = 0;
   localparam int OM_LSB    = 4;
   localparam int CTL_MIN_W = OM_LSB + OM_W;

   typedef enum logic [OM_W-1:0] {
      OM_OFF    = 2'b00,
      OM_TOGGLE = 2'b01,
      OM_CLEAR  = 2'b10,
      OM_SET    = 2'b11
   } out_mode_t;

   typedef struct packed {
      logic pwm;
      logic top_is_cmp;
      logic wide_toggle;
   } wave_dec_t;

   function automatic wave_dec_t decode_wave(input logic [WM_W-1:0] code);
      wave_dec_t d;
      d = '0;
      case (code)
         3'b010: d.top_is_cmp = 1'b1;
         3'b011: d.pwm        = 1'b1;
         3'b111: begin
            d.pwm        = 1'b1;
            d.top_is_cmp = 1'b1;
         end
         default: d = '0;
      endcase
      d.wide_toggle = code[WM_W-1];
      return d;
   endfunction

endpackage

// File: rtl/cwu_regs.sv
module cwu_regs
   import cwu_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              pwm,
   input  logic              wrap_load,
   output logic [WM_W-1:0]   wave_mode,
   output out_mode_t         out_mode,
   output logic [CNT_W-1:0]  cmp_act
);

   localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_W'(1);

   generate
      if (CNT_W < CTL_MIN_W) begin : g_bad_width
         $error("cwu_regs: CNT_W too small for the control fields");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("cwu_regs: ADDR_W must be at least 1");
      end
   endgenerate

   logic             ctl_hit;
   logic             cmp_hit;
   logic [CNT_W-1:0] cmp_buf;

   assign ctl_hit = wr_en && (wr_addr == CTL_ADDR);
   assign cmp_hit = wr_en && (wr_addr == CMP_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave_mode <= '0;
         out_mode  <= OM_OFF;
      end else if (ctl_hit) begin
         wave_mode <= wr_data[WM_LSB +: WM_W];
         out_mode  <= out_mode_t'(wr_data[OM_LSB +: OM_W]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_buf <= '0;
      end else if (cmp_hit) begin
         cmp_buf <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_act <= '0;
      end else if (pwm) begin
         if (wrap_load) begin
            cmp_act <= cmp_buf;
         end
      end else if (cmp_hit) begin
         cmp_act <= wr_data;
      end
   end

endmodule

// File: rtl/cwu_counter.sv
module cwu_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             top_is_cmp,
   input  logic [CNT_W-1:0] cmp_act,
   output logic [CNT_W-1:0] cnt,
   output logic             at_top,
   output logic             match
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] top_val;

   assign top_val = top_is_cmp ? cmp_act : CNT_MAX;
   assign at_top  = (cnt == top_val);
   assign match   = (cnt == cmp_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= at_top ? '0 : cnt + CNT_ONE;
      end
   end

endmodule

// File: rtl/cwu_outlogic.sv
module cwu_outlogic
   import cwu_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      pwm,
   input  logic      wide_toggle,
   input  out_mode_t out_mode,
   input  logic      match,
   input  logic      at_top,
   input  logic      dir,
   output logic      wave,
   output logic      wave_oe
);

   logic wave_nxt;
   logic pin_free;

   always_comb begin
      wave_nxt = wave;
      if (tick) begin
         if (!pwm) begin
            if (match) begin
               case (out_mode)
                  OM_TOGGLE: wave_nxt = ~wave;
                  OM_CLEAR:  wave_nxt = 1'b0;
                  OM_SET:    wave_nxt = 1'b1;
                  default:   wave_nxt = wave;
               endcase
            end
         end else begin
            case (out_mode)
               OM_TOGGLE: begin
                  if (wide_toggle && match) wave_nxt = ~wave;
               end
               OM_CLEAR: begin
                  if (at_top)     wave_nxt = 1'b1;
                  else if (match) wave_nxt = 1'b0;
               end
               OM_SET: begin
                  if (at_top)     wave_nxt = 1'b0;
                  else if (match) wave_nxt = 1'b1;
               end
               default: wave_nxt = wave;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wave <= 1'b0;
      else        wave <= wave_nxt;
   end

   assign pin_free = (out_mode == OM_OFF) ||
                     (pwm && (out_mode == OM_TOGGLE) && !wide_toggle);
   assign wave_oe  = dir && !pin_free;

endmodule

// File: rtl/cwu_top.sv
module cwu_top
   import cwu_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              tick_i,
   input  logic              pin_dir_i,
   output logic [CNT_W-1:0]  count_o,
   output logic              wave_o,
   output logic              wave_oe_o
);

   logic [WM_W-1:0]  wm_w;
   out_mode_t        om_w;
   wave_dec_t        dec_w;
   logic [CNT_W-1:0] cmp_act_w;
   logic             at_top_w;
   logic             match_w;

   assign dec_w = decode_wave(wm_w);

   cwu_regs #(
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .pwm       (dec_w.pwm),
      .wrap_load (tick_i && at_top_w),
      .wave_mode (wm_w),
      .out_mode  (om_w),
      .cmp_act   (cmp_act_w)
   );

   cwu_counter #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_i),
      .top_is_cmp (dec_w.top_is_cmp),
      .cmp_act    (cmp_act_w),
      .cnt        (count_o),
      .at_top     (at_top_w),
      .match      (match_w)
   );

   cwu_outlogic out_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick_i),
      .pwm         (dec_w.pwm),
      .wide_toggle (dec_w.wide_toggle),
      .out_mode    (om_w),
      .match       (match_w),
      .at_top      (at_top_w),
      .dir         (pin_dir_i),
      .wave        (wave_o),
      .wave_oe     (wave_oe_o)
   );

endmodule

// File: rtl/cwu_chk.sv
module cwu_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             dir,
   input logic             pwm,
   input logic             at_top,
   input logic             match,
   input logic [1:0]       omode,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp_act,
   input logic             wave,
   input logic             oe
);

   // R3: no tick, no movement of counter or output
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(cnt) && $stable(wave)));

   // R3: tick at TOP returns to zero
   assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_top) |=> (cnt == '0));

   // R4: direction low means the pin is never claimed
   assert_dir_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dir |-> !oe);

   // R4: mode 00 never claims the pin
   assert_off_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (omode == 2'b00) |-> !oe);

   // R5: non-PWM set on match
   assert_set_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !pwm && match && omode == 2'b11) |=> wave);

   // R5: non-PWM clear on match
   assert_clr_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !pwm && match && omode == 2'b10) |=> !wave);

   // R6: non-inverting PWM is high after the wrap
   assert_bottom_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && pwm && at_top && omode == 2'b10) |=> wave);

   // R7: inverting PWM is low after the wrap
   assert_bottom_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && pwm && at_top && omode == 2'b11) |=> !wave);

   // R10: in PWM the active compare only moves at a wrap tick
   assert_buffer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm && !(tick && at_top)) |=> $stable(cmp_act));

   // R11: mode 00 keeps the output level
   assert_off_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (omode == 2'b00) |=> $stable(wave));

endmodule

bind cwu_top cwu_chk #(.CNT_W(CNT_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick_i),
   .dir     (pin_dir_i),
   .pwm     (dec_w.pwm),
   .at_top  (at_top_w),
   .match   (match_w),
   .omode   (om_w),
   .cnt     (count_o),
   .cmp_act (cmp_act_w),
   .wave    (wave_o),
   .oe      (wave_oe_o)
);

// File: tb/cwu_top_tb.sv
module cwu_top_tb_top;

   localparam int W = 8;

   logic         clk     = 1'b0;
   logic         rst_n   = 1'b0;
   logic         wr_en   = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         tick    = 1'b0;
   logic         dir     = 1'b1;
   logic [W-1:0] count;
   logic         wave;
   logic         oe;

   always #5 clk = ~clk;

   cwu_top #(.CNT_W(W), .ADDR_W(2)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .tick_i    (tick),
      .pin_dir_i (dir),
      .count_o   (count),
      .wave_o    (wave),
      .wave_oe_o (oe)
   );

   typedef struct {
      logic [W-1:0] cnt;
      logic         wave;
      logic         oe;
      string        req;
   } exp_t;

   exp_t  sb_q[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;
   string cur_req = "R1";
   logic  dir_want = 1'b1;

   // reference state built from the requirements
   logic [W-1:0] m_cnt = '0;
   logic [W-1:0] m_act = '0;
   logic [W-1:0] m_buf = '0;
   logic [2:0]   m_wm  = '0;
   logic [1:0]   m_om  = '0;
   logic         m_out = 1'b0;

   function automatic logic is_pwm(input logic [2:0] c);
      return (c == 3'b011) || (c == 3'b111);
   endfunction

   function automatic void model_step(input logic t, input logic we,
                                      input logic [1:0] a, input logic [W-1:0] d);
      logic         pwm;
      logic [W-1:0] top;
      logic [W-1:0] ncnt;
      logic [W-1:0] nact;
      logic         nout;
      pwm  = is_pwm(m_wm);
      top  = ((m_wm == 3'b010) || (m_wm == 3'b111)) ? m_act : {W{1'b1}};
      ncnt = m_cnt;
      nact = m_act;
      nout = m_out;
      if (t) begin
         if (!pwm) begin
            if (m_cnt == m_act) begin
               if (m_om == 2'b01) nout = ~m_out;      // R5 toggle
               if (m_om == 2'b10) nout = 1'b0;        // R5 clear
               if (m_om == 2'b11) nout = 1'b1;        // R5 set
            end
         end else begin
            if (m_om == 2'b01 && m_wm[2] && m_cnt == m_act) nout = ~m_out;   // R8
            if (m_om == 2'b10) begin                                          // R6, R9
               if (m_cnt == top) nout = 1'b1;
               else if (m_cnt == m_act) nout = 1'b0;
            end
            if (m_om == 2'b11) begin                                          // R7, R9
               if (m_cnt == top) nout = 1'b0;
               else if (m_cnt == m_act) nout = 1'b1;
            end
         end
         ncnt = (m_cnt == top) ? '0 : m_cnt + 1'b1;
         if (pwm && m_cnt == top) nact = m_buf;                               // R10
      end
      if (we && a == 2'd1) begin
         if (!pwm) nact = d;
         m_buf = d;
      end
      if (we && a == 2'd0) begin
         m_wm = d[2:0];
         m_om = d[5:4];
      end
      m_cnt = ncnt;
      m_act = nact;
      m_out = nout;
   endfunction

   function automatic logic model_oe();
      if (!dir_want || m_om == 2'b00) return 1'b0;
      if (is_pwm(m_wm) && m_om == 2'b01 && !m_wm[2]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic cyc(input logic t, input logic we = 1'b0,
                      input logic [1:0] a = 2'd0, input logic [W-1:0] d = '0);
      exp_t e;
      @(negedge clk);
      tick    = t;
      wr_en   = we;
      wr_addr = a;
      wr_data = d;
      dir     = dir_want;
      model_step(t, we, a, d);
      e.cnt  = m_cnt;
      e.wave = m_out;
      e.oe   = model_oe();
      e.req  = cur_req;
      sb_q.push_back(e);
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      cyc(1'b0, 1'b1, a, d);
   endtask

   task automatic run(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         cyc((gap == 0) || ((i % gap) != 0));
      end
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // monitor: pops one expected item per edge after the driver queued it
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            chk(e.req, "count", 32'(count), 32'(e.cnt));
            chk(e.req, "wave",  32'(wave),  32'(e.wave));
            chk(e.req, "oe",    32'(oe),    32'(e.oe));
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired, run hung (actual=running expected=done)");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "count", 32'(count), 32'd0);
      chk("R1", "wave",  32'(wave),  32'd0);
      chk("R1", "oe",    32'(oe),    32'd0);
      rst_n = 1'b1;
      cur_req = "R1";
      run(4, 0);

      // R2: map, ignored address, free-run toggle
      cur_req = "R2";
      wr(2'd0, 8'h10);
      wr(2'd1, 8'd3);
      wr(2'd2, 8'h37);
      wr(2'd3, 8'h05);
      run(20, 0);
      cur_req = "R3";
      run(600, 7);

      // R5: clear and set in free run
      cur_req = "R5";
      wr(2'd0, 8'h20);
      run(300, 0);
      wr(2'd0, 8'h30);
      run(300, 0);

      // R3: clear-on-compare with toggle
      cur_req = "R3";
      wr(2'd1, 8'd10);
      wr(2'd0, 8'h12);
      run(320, 5);

      // R4: direction bit gating
      cur_req = "R4";
      dir_want = 1'b0;
      run(6, 0);
      dir_want = 1'b1;
      run(4, 0);

      // R6: non-inverting fast PWM, then R10 buffered compare
      cur_req = "R6";
      wr(2'd0, 8'h23);
      wr(2'd1, 8'd100);
      run(600, 0);
      cur_req = "R10";
      run(50, 0);
      wr(2'd1, 8'd200);
      run(600, 0);

      // R7: inverting fast PWM
      cur_req = "R7";
      wr(2'd0, 8'h33);
      run(600, 0);

      // R9: compare equals TOP
      cur_req = "R9";
      wr(2'd1, 8'hFF);
      run(600, 0);
      wr(2'd0, 8'h23);
      run(300, 0);
      wr(2'd1, 8'd50);
      run(300, 0);
      wr(2'd0, 8'h27);
      run(200, 0);
      wr(2'd0, 8'h37);
      run(200, 0);

      // R8: toggle in fast PWM, disconnected vs compare-top
      cur_req = "R8";
      wr(2'd0, 8'h13);
      run(300, 0);
      wr(2'd0, 8'h17);
      wr(2'd1, 8'd20);
      run(200, 0);

      // R11: output mode off holds, re-enable continues
      cur_req = "R11";
      wr(2'd0, 8'h07);
      run(100, 0);
      wr(2'd0, 8'h17);
      run(100, 0);

      // R10: immediate compare write in free run
      cur_req = "R10";
      wr(2'd0, 8'h10);
      run(300, 0);
      wr(2'd1, 8'h40);
      run(300, 0);

      repeat (3) @(posedge clk);
      #3;
      finish_run();
   end

endmodule